// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external host reach an internal register space over a four-wire serial link: a serial clock, a host-to-slave data line, a slave-to-host data line and an active-low select. All link signals are brought into the system clock domain through two-stage synchronisers. Clock edges are found by comparing successive synchronised samples, so the system clock must run several times faster than the serial clock.

Three static inputs configure the link. One sets the clock idle level, one picks the sampling edge, and one sets the bit order of the address and data fields. Every transaction opens with a 16-bit control word. Its first bit is a direction flag, the next fourteen bits are the register address and its last bit enables bursts. The bit-order input never moves the flag or the burst bit.

A data byte follows the control word. On the internal side the block drives a registered register bus with address, write data, a write strobe and a read strobe, and it takes read data back one clock after each read strobe. With the burst bit set, further bytes may follow while select stays low. The address steps by one after every byte.

Top module: `spi_reg_slave`

## Requirements
- R1: During and after synchronous reset, `spi_miso_oe`, `reg_wr` and `reg_rd` are low until a frame begins.
- R2: All four combinations of `cfg_cpol` (idle level of `spi_sck`) and `cfg_cpha` (0: capture on the edge leaving idle and change data on the return edge; 1: the reverse) transfer frames correctly.
- R3: The control word is 16 bits. Bit position 0 in time is the direction flag (1 = read). Positions 1 to 14 carry the address. Position 15 is the burst bit. The direction flag and the burst bit keep these positions for either bit order.
- R4: With `cfg_lsb_first` = 0, the address and data fields travel most-significant bit first. With `cfg_lsb_first` = 1 they travel least-significant bit first. This applies to both the host-to-slave and the slave-to-host line.
- R5: In a write, once the eighth data bit has been captured, the block raises `reg_wr` for exactly one cycle with the frame's address and the received byte. `reg_wr` and `reg_rd` are never high together.
- R6: In a read, the block raises `reg_rd` for one cycle with the address as soon as the control word completes. It takes `reg_rdata` on the following clock and shifts that byte out on `spi_miso` in the selected order, starting with the first data bit.
- R7: When the burst bit is 1, every further byte goes to the next address. Addresses wrap modulo 2^14. In a read burst, each completed byte triggers a read of the next address, so the byte is ready before its first bit is due.
- R8: When the burst bit is 0, bits sent after the first data byte cause no further register access until select rises.
- R9: Raising `spi_cs_n` mid-frame aborts the frame without any register access. The next frame then decodes from its first bit.
- R10: `spi_miso_oe` is high while the synchronised select is low and goes low three clocks after `spi_cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Static serial clock idle level |
| cfg_cpha | input | 1 | Static sampling-edge select |
| cfg_lsb_first | input | 1 | Static bit order for address and data fields |
| spi_sck | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` pad |
| reg_addr | output | ADDR_W | Register bus address |
| reg_wdata | output | DATA_W | Register bus write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W | Read data, valid the clock after `reg_rd` |

## Verification
A host edge reaches the internal edge event after two synchroniser stages and one compare stage. A register strobe follows one clock after that event, and `spi_miso` changes about five clocks after the host's shifting edge. The bench holds each serial half period for eight system clocks, so it samples `spi_miso` at its capture edge at least three clocks after the bit is due. Register-bus strobes are not checked at a fixed cycle. A monitor compares them in order against a queue that the driver fills before each frame, so any missing, extra or reordered access is caught wherever it lands.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [1:0] {
    PH_CTRL = 2'd0,
    PH_DATA = 2'd1,
    PH_HOLD = 2'd2
  } frame_phase_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic cpol,
  input  logic cpha,
  output logic sample_evt,
  output logic shift_evt
);
  logic lvl, prev_lvl, lead, trail;

  // level relative to idle: 0 = idle, 1 = active
  assign lvl = sck_s ^ cpol;

  always_ff @(posedge clk) begin
    if (rst) prev_lvl <= 1'b0;
    else     prev_lvl <= lvl;
  end

  assign lead       = lvl & ~prev_lvl;
  assign trail      = ~lvl & prev_lvl;
  assign sample_evt = cpha ? trail : lead;
  assign shift_evt  = cpha ? lead : trail;
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              mosi_s,
  input  logic              sample_evt,
  input  logic              shift_evt,
  input  logic              lsb_first,
  output logic              miso,
  output logic              miso_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CTRL_W = ADDR_W + 2;
  localparam int MAX_W  = (CTRL_W > DATA_W) ? CTRL_W : DATA_W;
  localparam int CNT_W  = $clog2(MAX_W);
  localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  frame_phase_t      phase;
  logic [CNT_W-1:0]  cnt;
  logic              rw_q, burst_q, first_seen, rd_pend;
  logic [ADDR_W-1:0] addr_sr, cur_addr, addr_nx;
  logic [DATA_W-1:0] rx_sr, rx_nx, tx_sr, tx_shifted;
  logic              tx_bit;

  always_comb begin
    if (lsb_first) begin
      addr_nx    = {mosi_s, addr_sr[ADDR_W-1:1]};
      rx_nx      = {mosi_s, rx_sr[DATA_W-1:1]};
      tx_bit     = tx_sr[0];
      tx_shifted = {1'b0, tx_sr[DATA_W-1:1]};
    end else begin
      addr_nx    = {addr_sr[ADDR_W-2:0], mosi_s};
      rx_nx      = {rx_sr[DATA_W-2:0], mosi_s};
      tx_bit     = tx_sr[DATA_W-1];
      tx_shifted = {tx_sr[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_CTRL;
      cnt        <= '0;
      rw_q       <= 1'b0;
      burst_q    <= 1'b0;
      first_seen <= 1'b0;
      rd_pend    <= 1'b0;
      addr_sr    <= '0;
      cur_addr   <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      miso       <= 1'b0;
      miso_oe    <= 1'b0;
    end else begin
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      rd_pend <= reg_rd;
      miso    <= tx_bit;
      miso_oe <= cs_act;
      if (!cs_act) begin
        phase      <= PH_CTRL;
        cnt        <= '0;
        first_seen <= 1'b0;
        tx_sr      <= '0;
      end else begin
        if (sample_evt) begin
          case (phase)
            PH_CTRL: begin
              cnt <= cnt + 1'b1;
              if (cnt == '0) begin
                rw_q <= mosi_s;
              end else if (cnt == CTRL_LAST) begin
                burst_q    <= mosi_s;
                phase      <= PH_DATA;
                cnt        <= '0;
                first_seen <= 1'b0;
                cur_addr   <= addr_sr;
                if (rw_q) begin
                  reg_rd   <= 1'b1;
                  reg_addr <= addr_sr;
                end
              end else begin
                addr_sr <= addr_nx;
              end
            end
            PH_DATA: begin
              rx_sr <= rx_nx;
              cnt   <= cnt + 1'b1;
              if (cnt == DATA_LAST) begin
                cnt        <= '0;
                first_seen <= 1'b0;
                cur_addr   <= cur_addr + 1'b1;
                if (!rw_q) begin
                  reg_wr    <= 1'b1;
                  reg_addr  <= cur_addr;
                  reg_wdata <= rx_nx;
                end else if (burst_q) begin
                  reg_rd   <= 1'b1;
                  reg_addr <= cur_addr + 1'b1;
                end
                if (!burst_q) phase <= PH_HOLD;
              end
            end
            default: ;
          endcase
        end
        if (shift_evt && phase == PH_DATA && rw_q) begin
          if (!first_seen) first_seen <= 1'b1;
          else             tx_sr      <= tx_shifted;
        end
        if (rd_pend) tx_sr <= reg_rdata;
      end
    end
  end

  // R5
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd)) else $error("write and read strobes overlap");

  // R5
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr) else $error("write strobe longer than one cycle");

  // R9
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !(reg_wr || reg_rd)) else $error("strobe without active select");

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD && $past(phase == PH_HOLD)) |-> !(reg_wr || reg_rd))
    else $error("register access after single byte");
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [2:0] raw_in, sync_out;
  logic       sck_s, mosi_s, cs_n_s, sample_evt, shift_evt;

  assign raw_in = {spi_cs_n, spi_mosi, spi_sck};
  assign {cs_n_s, mosi_s, sck_s} = sync_out;

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  spi_edge_det u_edge (
    .clk(clk), .rst(rst), .sck_s(sck_s), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .sample_evt(sample_evt), .shift_evt(shift_evt)
  );

  spi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .cs_act(~cs_n_s), .mosi_s(mosi_s),
    .sample_evt(sample_evt), .shift_evt(shift_evt), .lsb_first(cfg_lsb_first),
    .miso(spi_miso), .miso_oe(spi_miso_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // R10
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(spi_cs_n, 3) |-> !spi_miso_oe) else $error("output enable after select release");
endmodule

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  localparam int AW = 14;
  localparam int DW = 8;
  localparam int HALF = 8;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } bus_item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
  logic spi_miso, spi_miso_oe, reg_wr, reg_rd;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R1";
  bus_item_t exp_q[$];
  bus_item_t mon_it;

  always #10 clk = ~clk;

  spi_reg_slave #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[13:8], 2'b10};
  endfunction

  // register file model: data valid the clock after the read strobe
  always_ff @(posedge clk) if (reg_rd) reg_rdata <= pat(reg_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (reg_wr || reg_rd)) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL %s unexpected access actual=wr%0b/rd%0b@%h expected=none",
                 cur_tag, reg_wr, reg_rd, reg_addr);
      end else begin
        mon_it = exp_q.pop_front();
        if (mon_it.wr)
          chk(cur_tag, {9'd0, reg_wr, reg_rd, reg_addr, reg_wdata},
              {9'd0, 1'b1, 1'b0, mon_it.addr, mon_it.data});
        else
          chk(cur_tag, {17'd0, reg_wr, reg_rd, reg_addr},
              {17'd0, 1'b0, 1'b1, mon_it.addr});
      end
    end
  end

  task automatic hwait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic r);
    if (!cfg_cpha) begin
      spi_mosi = b;
      hwait();
      spi_sck = ~cfg_cpol;
      r = spi_miso;
      hwait();
      spi_sck = cfg_cpol;
    end else begin
      spi_sck = ~cfg_cpol;
      spi_mosi = b;
      hwait();
      spi_sck = cfg_cpol;
      r = spi_miso;
      hwait();
    end
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic lsb);
    @(negedge clk);
    cfg_cpol = pol;
    cfg_cpha = pha;
    cfg_lsb_first = lsb;
    spi_sck = pol;
    repeat (4) @(negedge clk);
  endtask

  // driver: pushes expected bus items, then runs one frame
  task automatic spi_xact(input string tag, input logic rw, input logic [AW-1:0] a,
                          input logic burst, input int nbytes, input logic [31:0] wb);
    logic r;
    logic [DW-1:0] got;
    int nacc;
    nacc = burst ? nbytes : 1;
    cur_tag = tag;
    for (int i = 0; i < nacc; i++) begin
      if (rw) exp_q.push_back('{1'b0, AW'(a + i), 8'h00});
      else    exp_q.push_back('{1'b1, AW'(a + i), wb[8*i +: 8]});
    end
    if (rw && burst) exp_q.push_back('{1'b0, AW'(a + nbytes), 8'h00});
    @(negedge clk);
    spi_cs_n = 1'b0;
    hwait();
    chk({tag, "/R10 oe during frame"}, {31'd0, spi_miso_oe}, 32'd1);
    xfer_bit(rw, r);
    for (int k = 0; k < AW; k++)
      xfer_bit(cfg_lsb_first ? a[k] : a[AW-1-k], r);
    xfer_bit(burst, r);
    for (int i = 0; i < nbytes; i++) begin
      got = '0;
      for (int k = 0; k < DW; k++) begin
        xfer_bit(cfg_lsb_first ? wb[8*i + k] : wb[8*i + DW-1-k], r);
        if (cfg_lsb_first) got = {r, got[DW-1:1]};
        else               got = {got[DW-2:0], r};
      end
      if (rw && i < nacc) chk({tag, " read byte"}, {24'd0, got}, {24'd0, pat(AW'(a + i))});
    end
    hwait();
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    chk({tag, " queue drained"}, exp_q.size(), 32'd0);
  endtask

  task automatic spi_abort(input int nbits);
    logic r;
    cur_tag = "R9";
    @(negedge clk);
    spi_cs_n = 1'b0;
    hwait();
    for (int k = 0; k < nbits; k++) xfer_bit(k[0] ^ k[2], r);
    spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9/R10 oe after abort", {31'd0, spi_miso_oe}, 32'd0);
    repeat (4 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", {31'd0, spi_miso_oe}, 32'd0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", {31'd0, spi_miso_oe}, 32'd0);
    chk("R1 strobes after reset", {30'd0, reg_wr, reg_rd}, 32'd0);

    set_mode(1'b0, 1'b0, 1'b0);
    spi_xact("R2 R3 R5 mode00 write", 1'b0, 14'h01A5, 1'b0, 1, 32'h3C);
    set_mode(1'b0, 1'b1, 1'b0);
    spi_xact("R2 mode01 write", 1'b0, 14'h2A55, 1'b0, 1, 32'hC3);
    set_mode(1'b1, 1'b0, 1'b0);
    spi_xact("R2 mode10 write", 1'b0, 14'h1234, 1'b0, 1, 32'h5A);
    set_mode(1'b1, 1'b1, 1'b0);
    spi_xact("R2 mode11 write", 1'b0, 14'h3FFF, 1'b0, 1, 32'hA5);

    set_mode(1'b0, 1'b0, 1'b1);
    spi_xact("R4 R3 lsb-first write", 1'b0, 14'h2001, 1'b0, 1, 32'h81);
    set_mode(1'b0, 1'b0, 1'b0);
    spi_xact("R6 read mode00", 1'b1, 14'h0040, 1'b0, 1, 32'h0);
    set_mode(1'b1, 1'b1, 1'b1);
    spi_xact("R6 R4 read lsb mode11", 1'b1, 14'h1C37, 1'b0, 1, 32'h0);

    set_mode(1'b0, 1'b1, 1'b0);
    spi_xact("R7 burst write wrap", 1'b0, 14'h3FFE, 1'b1, 3, 32'h00_77_66_11);
    set_mode(1'b1, 1'b0, 1'b1);
    spi_xact("R7 burst read", 1'b1, 14'h0805, 1'b1, 3, 32'h0);
    set_mode(1'b0, 1'b0, 1'b0);
    spi_xact("R7 burst read wrap", 1'b1, 14'h3FFF, 1'b1, 2, 32'h0);

    spi_xact("R8 single write extra bits", 1'b0, 14'h0100, 1'b0, 2, 32'h0000_EE42);
    spi_xact("R8 single read extra bits", 1'b1, 14'h0200, 1'b0, 2, 32'h0);

    spi_abort(20);
    spi_abort(9);
    spi_xact("R9 frame after abort", 1'b0, 14'h0ABC, 1'b0, 1, 32'h96);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule